// File: doc/BRIEF.md
# Status LED Driver

This block drives three active-high status LEDs from a small set of network-port indications: a 10 Mb link flag, a 100 Mb link flag, and single-cycle strobes for collision, transmit and receive events. Each LED has its own 3-bit source selector and its own receive-activity enable. Activity strobes are stretched by restartable hold timers, so that a one-clock event stays visible for 2^STRETCH_W clocks. The selected source is then combined with the stretched receive activity when that LED's enable is set.

Two write-only configuration registers hold the selectors. They are written through a one-cycle write strobe, a register select line and an 8-bit data bus. Register 0 serves LED0 and LED1. Register 1 serves LED2.

An automatic mode runs a shared four-state machine with these states:
- `AUTO_NOLINK`: no link, LED dark.
- `AUTO_STEADY`: link up, LED lit.
- `AUTO_DARK`: a forced dark phase.
- `AUTO_LIT`: a forced lit phase.

The transitions are:
- NOLINK→STEADY when either link flag rises.
- STEADY→DARK on any transmit or receive strobe.
- DARK→LIT when its timer expires.
- LIT→STEADY when its timer expires.
- Any state→NOLINK when both link flags are low.

Each stretcher is a two-state machine. `STR_IDLE` moves to `STR_HOLD` on a strobe. `STR_HOLD` reloads its timer on a further strobe and returns to `STR_IDLE` when the timer expires.

Top module: `led_status_drv`

## Requirements
- R1: While reset is asserted and right after its release, all three LED outputs are 0 and every selector is off.
- R2: A write with select 0 stores LED0's selector from data bits 2:0, LED1's selector from bits 5:3, LED0's receive-add enable from bit 6 and LED1's from bit 7. The new setting reaches the outputs two clocks after the write cycle.
- R3: A write with select 1 stores LED2's selector from bits 2:0 and its receive-add enable from bit 6. Bits 3, 4, 5 and 7 are ignored, and register 0 is left unchanged.
- R4: Selector code 000 (off) keeps the LED at 0 whatever the inputs do, unless its receive-add enable is set.
- R5: With code 001 (collision) or 111 (transmit), a one-cycle strobe drives the LED high from the second clock after the strobe for exactly 2^STRETCH_W clocks.
- R6: A strobe that arrives while its hold window is running restarts the full window from that strobe.
- R7: Code 010 (inverted collision) gives an LED that is 1 when idle and 0 during the stretched collision window.
- R8: Codes 011 (10 Mb link), 100 (100 Mb link) and 101 (either link) follow the link flags with one clock of latency.
- R9: With the receive-add enable set, the LED is the OR of the selected source and the stretched receive activity.
- R10: Code 110 (automatic) behaves as follows:
  - With a link up, the LED is lit steadily, starting two clocks after the link rises.
  - A transmit or receive strobe while steady gives exactly 2^STRETCH_W dark clocks, then 2^STRETCH_W forced lit clocks.
  - Strobes during the dark or lit phase are ignored.
- R11: In automatic mode, losing both link flags turns the LED off two clocks later, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = LED0/LED1 register, 1 = LED2 register |
| wr_data | input | 8 | Register write data |
| link10_i | input | 1 | 10 Mb link up |
| link100_i | input | 1 | 100 Mb link up |
| col_evt_i | input | 1 | Collision event strobe |
| tx_evt_i | input | 1 | Transmit event strobe |
| rx_evt_i | input | 1 | Receive event strobe |
| led_o | output | 3 | Registered LED drives, bit n = LEDn |

## Verification
The bench builds the block with STRETCH_W = 4, which gives 16-clock hold windows. With windows that short, the bench can reach and observe several events:
- the exact last lit clock and first dark clock of a stretched pulse;
- a retrigger that extends a window;
- a complete dark-then-lit automatic blink, with ignored strobes in both phases.

The default width of 20 behaves the same, but its windows are about a million clocks long.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    localparam int NUM_LEDS = 3;

    typedef enum logic [2:0] {
        SRC_OFF     = 3'd0,
        SRC_COL     = 3'd1,
        SRC_NCOL    = 3'd2,
        SRC_LINK10  = 3'd3,
        SRC_LINK100 = 3'd4,
        SRC_LINKANY = 3'd5,
        SRC_AUTO    = 3'd6,
        SRC_TX      = 3'd7
    } led_src_e;

    typedef enum logic {
        STR_IDLE,
        STR_HOLD
    } stretch_state_e;

    typedef enum logic [1:0] {
        AUTO_NOLINK,
        AUTO_STEADY,
        AUTO_DARK,
        AUTO_LIT
    } auto_state_e;

    typedef struct packed {
        led_src_e src;
        logic     rx_add;
    } led_cfg_t;

endpackage

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch
    import led_drv_pkg::*;
#(
    parameter int STRETCH_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic active_o
);
    localparam logic [STRETCH_W-1:0] LOAD = '1;

    stretch_state_e state, state_nxt;
    logic [STRETCH_W-1:0] cnt, cnt_nxt;

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            STR_IDLE: begin
                if (strobe_i) begin
                    state_nxt = STR_HOLD;
                    cnt_nxt   = LOAD;
                end
            end
            STR_HOLD: begin
                if (strobe_i) begin
                    cnt_nxt = LOAD;
                end else if (cnt == '0) begin
                    state_nxt = STR_IDLE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= STR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        active_o = (state == STR_HOLD);
    end

    // R5
    stretch_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> active_o);

    // R5
    stretch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !strobe_i) |=> !active_o);

    // R6
    stretch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && strobe_i) |=> (active_o && cnt == LOAD));

endmodule

// File: rtl/led_auto_blink.sv
module led_auto_blink
    import led_drv_pkg::*;
#(
    parameter int STRETCH_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_i,
    input  logic act_i,
    output logic lit_o
);
    localparam logic [STRETCH_W-1:0] LOAD = '1;

    auto_state_e state, state_nxt;
    logic [STRETCH_W-1:0] cnt, cnt_nxt;

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            AUTO_NOLINK: begin
                if (link_i) state_nxt = AUTO_STEADY;
            end
            AUTO_STEADY: begin
                if (!link_i) begin
                    state_nxt = AUTO_NOLINK;
                end else if (act_i) begin
                    state_nxt = AUTO_DARK;
                    cnt_nxt   = LOAD;
                end
            end
            AUTO_DARK: begin
                if (!link_i) begin
                    state_nxt = AUTO_NOLINK;
                end else if (cnt == '0) begin
                    state_nxt = AUTO_LIT;
                    cnt_nxt   = LOAD;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            AUTO_LIT: begin
                if (!link_i) begin
                    state_nxt = AUTO_NOLINK;
                end else if (cnt == '0) begin
                    state_nxt = AUTO_STEADY;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= AUTO_NOLINK;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        lit_o = (state == AUTO_STEADY) || (state == AUTO_LIT);
    end

    // R11
    auto_linkloss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_i |=> !lit_o);

    // R10
    auto_blink_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_i && act_i && state == AUTO_STEADY) |=> !lit_o);

    // R10
    auto_dark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_i && state == AUTO_DARK && cnt != '0) |=> (state == AUTO_DARK));

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_drv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [7:0]               wr_data,
    output led_cfg_t [NUM_LEDS-1:0]  cfg_o
);
    led_cfg_t [NUM_LEDS-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LEDS; i++) begin
                cfg_q[i] <= '{src: SRC_OFF, rx_add: 1'b0};
            end
        end else if (wr_en) begin
            if (!wr_sel) begin
                cfg_q[0].src    <= led_src_e'(wr_data[2:0]);
                cfg_q[1].src    <= led_src_e'(wr_data[5:3]);
                cfg_q[0].rx_add <= wr_data[6];
                cfg_q[1].rx_add <= wr_data[7];
            end else begin
                cfg_q[2].src    <= led_src_e'(wr_data[2:0]);
                cfg_q[2].rx_add <= wr_data[6];
            end
        end
    end

    assign cfg_o = cfg_q;

    // R3
    cfg_pair_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> ($stable(cfg_o[0]) && $stable(cfg_o[1])));

    // R2
    cfg_third_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> $stable(cfg_o[2]));

endmodule

// File: rtl/led_src_sel.sv
module led_src_sel
    import led_drv_pkg::*;
(
    input  led_cfg_t cfg_i,
    input  logic     col_act_i,
    input  logic     tx_act_i,
    input  logic     rx_act_i,
    input  logic     link10_i,
    input  logic     link100_i,
    input  logic     auto_lit_i,
    output logic     led_d_o
);
    logic base;

    always_comb begin
        unique case (cfg_i.src)
            SRC_OFF:     base = 1'b0;
            SRC_COL:     base = col_act_i;
            SRC_NCOL:    base = ~col_act_i;
            SRC_LINK10:  base = link10_i;
            SRC_LINK100: base = link100_i;
            SRC_LINKANY: base = link10_i | link100_i;
            SRC_AUTO:    base = auto_lit_i;
            SRC_TX:      base = tx_act_i;
        endcase
        led_d_o = base | (cfg_i.rx_add & rx_act_i);
    end

endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
    import led_drv_pkg::*;
#(
    parameter int STRETCH_W = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       link10_i,
    input  logic       link100_i,
    input  logic       col_evt_i,
    input  logic       tx_evt_i,
    input  logic       rx_evt_i,
    output logic [2:0] led_o
);
    localparam int NUM_EVT = 3;

    led_cfg_t [NUM_LEDS-1:0] cfg_w;
    logic [NUM_EVT-1:0]      evt_w;
    logic [NUM_EVT-1:0]      act_w;
    logic                    auto_lit_w;
    logic [NUM_LEDS-1:0]     led_d_w;
    logic [NUM_LEDS-1:0]     led_q;

    assign evt_w = {rx_evt_i, tx_evt_i, col_evt_i};

    led_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_o   (cfg_w)
    );

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_str
        led_pulse_stretch #(.STRETCH_W(STRETCH_W)) u_str (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (evt_w[e]),
            .active_o (act_w[e])
        );
    end

    led_auto_blink #(.STRETCH_W(STRETCH_W)) u_auto (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_i (link10_i | link100_i),
        .act_i  (tx_evt_i | rx_evt_i),
        .lit_o  (auto_lit_w)
    );

    for (genvar l = 0; l < NUM_LEDS; l++) begin : g_led
        led_src_sel u_sel (
            .cfg_i      (cfg_w[l]),
            .col_act_i  (act_w[0]),
            .tx_act_i   (act_w[1]),
            .rx_act_i   (act_w[2]),
            .link10_i   (link10_i),
            .link100_i  (link100_i),
            .auto_lit_i (auto_lit_w),
            .led_d_o    (led_d_w[l])
        );

        // R4
        led_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_w[l].src == SRC_OFF && !cfg_w[l].rx_add) |=> !led_o[l]);

        // R9
        led_rx_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_w[l].rx_add && act_w[2]) |=> led_o[l]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) led_q <= '0;
        else        led_q <= led_d_w;
    end

    assign led_o = led_q;

endmodule

// File: tb/led_status_drv_test.sv
module led_status_drv_test;
    localparam int SW = 4;
    localparam int N  = 1 << SW;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_sel;
    logic [7:0] wr_data;
    logic       link10, link100, col_evt, tx_evt, rx_evt;
    logic [2:0] led_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int    at;
        int    idx;
        bit    val;
        string req;
    } exp_t;
    exp_t q[$];

    led_status_drv #(.STRETCH_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .link10_i(link10), .link100_i(link100),
        .col_evt_i(col_evt), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
        .led_o(led_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare queued expectations in their cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                checks++;
                if (led_o[q[i].idx] !== q[i].val) begin
                    errors++;
                    $display("FAIL %s led%0d cycle %0d: actual %b expected %b",
                             q[i].req, q[i].idx, cyc, led_o[q[i].idx], q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(int off, int idx, bit v, string req);
        q.push_back('{cyc + off, idx, v, req});
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // which: 0 = collision, 1 = transmit, 2 = receive
    task automatic strobe(int which);
        case (which)
            0: col_evt = 1'b1;
            1: tx_evt  = 1'b1;
            default: rx_evt = 1'b1;
        endcase
        tick(1);
        col_evt = 1'b0; tx_evt = 1'b0; rx_evt = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        link10 = 1'b1; link100 = 1'b1;
        col_evt = 1'b0; tx_evt = 1'b0; rx_evt = 1'b0;
        tick(3);
        checks++;
        if (led_o !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset: actual %b expected 000", led_o);
        end
        rst_n = 1'b1;
        // R1 R4: selectors off, all inputs busy, LEDs stay dark
        for (int k = 1; k <= 3; k++)
            for (int l = 0; l < 3; l++) expect_at(k, l, 1'b0, "R1 R4 off");
        col_evt = 1'b1; tx_evt = 1'b1; rx_evt = 1'b1;
        tick(1);
        col_evt = 1'b0; tx_evt = 1'b0; rx_evt = 1'b0;
        tick(N + 4);

        // R2 R8: LED0 = 10Mb link, LED1 = 100Mb link
        link10 = 1'b1; link100 = 1'b0;
        tick(2);
        wr(0, 8'h23);
        tick(2);
        expect_at(1, 0, 1'b1, "R2 R8 link10");
        expect_at(1, 1, 1'b0, "R2 R8 link100");
        tick(2);
        link100 = 1'b1;
        expect_at(1, 1, 1'b1, "R8 link100 rise");
        tick(2);

        // R8: either-speed link
        wr(0, 8'h2D);
        tick(2);
        link10 = 1'b0;
        expect_at(1, 0, 1'b1, "R8 any link");
        expect_at(1, 1, 1'b1, "R8 any link");
        tick(2);
        link100 = 1'b0;
        expect_at(1, 0, 1'b0, "R8 no link");
        expect_at(1, 1, 1'b0, "R8 no link");
        tick(2);
        link10 = 1'b1;

        // R3: LED2 register, ignored bits, pair register kept
        wr(1, 8'hBF);
        tick(3);
        expect_at(1, 0, 1'b1, "R3 pair kept");
        expect_at(1, 1, 1'b1, "R3 pair kept");
        tick(2);
        expect_at(2, 2, 1'b0, "R3 rx add clear");
        expect_at(N, 2, 1'b0, "R3 rx add clear");
        strobe(2);
        tick(N + 4);

        // R5: transmit stretch window on LED2
        expect_at(1, 2, 1'b0, "R5 before");
        expect_at(2, 2, 1'b1, "R5 first");
        expect_at(N + 1, 2, 1'b1, "R5 last");
        expect_at(N + 2, 2, 1'b0, "R5 end");
        strobe(1);
        tick(N + 4);

        // R6: retrigger after 5 cycles
        expect_at(2, 2, 1'b1, "R6 first");
        expect_at(N + 2, 2, 1'b1, "R6 extended");
        expect_at(N + 6, 2, 1'b1, "R6 last");
        expect_at(N + 7, 2, 1'b0, "R6 end");
        strobe(1);
        tick(4);
        strobe(1);
        tick(N + 8);

        // R7: LED0 collision, LED1 inverted collision
        link10 = 1'b0;
        wr(0, 8'h11);
        tick(3);
        expect_at(1, 0, 1'b0, "R7 idle col");
        expect_at(1, 1, 1'b1, "R7 idle ncol");
        tick(2);
        expect_at(1, 0, 1'b0, "R5 col before");
        expect_at(2, 0, 1'b1, "R5 col first");
        expect_at(N + 1, 0, 1'b1, "R5 col last");
        expect_at(N + 2, 0, 1'b0, "R5 col end");
        expect_at(1, 1, 1'b1, "R7 before");
        expect_at(2, 1, 1'b0, "R7 dark");
        expect_at(N + 1, 1, 1'b0, "R7 dark last");
        expect_at(N + 2, 1, 1'b1, "R7 back");
        strobe(0);
        tick(N + 4);

        // R9: receive OR on LED0 (off source) and LED2 (transmit source)
        wr(0, 8'h40);
        wr(1, 8'h47);
        tick(3);
        expect_at(2, 0, 1'b1, "R9 led0");
        expect_at(N + 1, 0, 1'b1, "R9 led0 last");
        expect_at(N + 2, 0, 1'b0, "R9 led0 end");
        expect_at(2, 1, 1'b0, "R9 led1 no add");
        expect_at(N, 1, 1'b0, "R9 led1 no add");
        expect_at(2, 2, 1'b1, "R9 led2");
        strobe(2);
        tick(N + 4);

        // R10: automatic mode
        wr(1, 8'h00);
        wr(0, 8'h36);
        tick(3);
        expect_at(1, 0, 1'b0, "R10 no link");
        expect_at(1, 1, 1'b0, "R10 no link");
        tick(2);
        link100 = 1'b1;
        expect_at(1, 0, 1'b0, "R10 link latency");
        expect_at(2, 0, 1'b1, "R10 steady");
        expect_at(2, 1, 1'b1, "R10 steady");
        tick(4);
        expect_at(1, 0, 1'b1, "R10 before blink");
        expect_at(2, 0, 1'b0, "R10 dark");
        expect_at(N + 1, 0, 1'b0, "R10 dark last");
        expect_at(N + 2, 0, 1'b1, "R10 lit");
        expect_at(N + 8, 0, 1'b1, "R10 lit strobe ignored");
        expect_at(2 * N + 2, 0, 1'b1, "R10 steady again");
        strobe(1);
        tick(2);
        strobe(2);
        tick(N + 1);
        strobe(1);
        tick(2 * N + 6);

        // R11: link loss from steady
        link100 = 1'b0;
        expect_at(1, 0, 1'b1, "R11 latency");
        expect_at(2, 0, 1'b0, "R11 off");
        expect_at(2, 1, 1'b0, "R11 off");
        tick(6);

        while (q.size() > 0) begin
            checks++; errors++;
            $display("FAIL %s led%0d: actual unchecked expected cycle %0d",
                     q[0].req, q[0].idx, q[0].at);
            q.delete(0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule